// File: doc/BRIEF.md
# Dot-Clock Raster Timing Generator

This block produces the raster timing for a parallel RGB panel clocked by a dot clock. From a small register port it takes the line and frame totals, the horizontal and vertical sync pulse widths, the wait counts that place the active window after the start of each sync pulse, and the active pixel and line counts. It drives horizontal sync, vertical sync and data-enable, each with a programmable polarity. It also drives a pixel-read strobe toward an upstream pixel FIFO and passes the FIFO word through to the panel data pins.

A current/next frame-buffer base address pair supplies the fetch address. Software writes the next base at any time. The block copies it into the current base on the cycle that a new frame starts, and it marks that cycle with a one-cycle frame-start pulse for the fetch logic. The sync outputs run whenever sync output is enabled, independently of the run bit. The run bit gates only data-enable and the FIFO reads. When run is cleared, the block keeps reading until the FIFO reports empty, and only then does run read back as zero.

Top module: `lcd_dotclk_timing`

## Requirements
- R1: After reset all registers read 0, all outputs show their inactive level and frame_start_o is 0. While sync output (CTRL bit 1) is 0, the line and pixel counters stay at 0 and all three sync/enable outputs stay inactive. When sync output is enabled, the first dot clock is pixel 0 of line 0.
- R2: A line lasts LINE_TOTAL dot clocks (register 0x10 bits [15:0]). Horizontal sync is active for the first HS_WIDTH clocks of each line (0x10 bits [31:16]).
- R3: A frame lasts FRAME_TOTAL lines (0x20 bits [15:0]). Vertical sync is active for the first VS_WIDTH whole lines of each frame (0x20 bits [31:16]).
- R4: Data-enable is active only while run is active, on pixels H_WAIT to H_WAIT+H_ACTIVE-1 of lines V_WAIT to V_WAIT+V_ACTIVE-1. H_WAIT is 0x30 bits [15:0] and V_WAIT is 0x30 bits [31:16]. H_ACTIVE is 0x40 bits [15:0] and V_ACTIVE is 0x40 bits [31:16].
- R5: CTRL bits 2, 3 and 4 select active-high (1) or active-low (0) for horizontal sync, vertical sync and data-enable. CTRL bit 5 is driven on dclk_fall_o to select falling-edge data launch.
- R6: frame_start_o is high for one dot clock at pixel 0 of line 0. The next-buffer register (0x50) is copied into the current-buffer register (0x60, read-only, driven on fetch_addr_o) only on that cycle.
- R7: Setting run (CTRL bit 0) is ignored unless sync output is already enabled. After run is cleared, run reads 1 and data continues while the FIFO is not empty. Run reads 0 from the cycle after the FIFO reports empty.
- R8: CTRL at 0x00 is written directly. A write to 0x04 sets the CTRL bits given as ones, and a write to 0x08 clears them.
- R9: During data-enable the block reads the FIFO and outputs its word. If the FIFO is empty on an active pixel, the last word is repeated and the sticky underflow flag (CTRL bit 8, underflow_o) is set. That flag is cleared only by a CTRL write that clears bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| fifo_empty_i | input | 1 | Upstream pixel FIFO empty |
| fifo_data_i | input | PW | FIFO head word |
| fifo_rd_o | output | 1 | Pixel read strobe |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pix_o | output | PW | Pixel data to panel |
| dclk_fall_o | output | 1 | Falling-edge data launch select |
| frame_start_o | output | 1 | One-clock frame-start pulse |
| fetch_addr_o | output | AW | Current frame-buffer base |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
On every cycle the assertions check four things: the FIFO is never read while empty, frame_start_o never lasts two clocks, the current base changes only on a frame start, and run can come up only with sync output enabled. They also check that run drops once a cleared run meets an empty FIFO. The exact placement of the sync pulses and the data window inside the line and the frame can only be shown by the bench's scenarios. The same holds for the ordering of pixel words, the repeated word on underflow, and the delayed take-up of a new base. The bench compares these against positions computed from the programmed totals and against a scoreboard of expected pixel words.

// File: rtl/lcd_dotclk_timing.sv
module lcd_dotclk_timing #(
  parameter int CW = 16,
  parameter int AW = 32,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          fifo_empty_i,
  input  logic [PW-1:0] fifo_data_i,
  output logic          fifo_rd_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [PW-1:0] pix_o,
  output logic          dclk_fall_o,
  output logic          frame_start_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          underflow_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          run_req, run_act, sync_on, hs_hi, vs_hi, de_hi, dclk_fall, uflow;
  logic [CW-1:0] line_tot, hs_w, frame_tot, vs_w, h_wait, v_wait, h_act, v_act;
  logic [CW-1:0] hcnt, vcnt;
  logic [AW-1:0] nxt_buf, cur_buf;
  logic [PW-1:0] last_pix;

  logic [3:0] rsel, rop;
  assign rsel = reg_addr_i[7:4];
  assign rop  = reg_addr_i[3:0];

  logic [8:0] ctrl_cur, ctrl_nxt;
  logic       ctrl_we, run_req_d;
  assign ctrl_cur = {uflow, 2'b00, dclk_fall, de_hi, vs_hi, hs_hi, sync_on, run_req};
  assign ctrl_we  = reg_wr_i && rsel == 4'h0 && (rop == 4'h0 || rop == 4'h4 || rop == 4'h8);

  always_comb begin
    case (rop)
      4'h4:    ctrl_nxt = ctrl_cur | reg_wdata_i[8:0];
      4'h8:    ctrl_nxt = ctrl_cur & ~reg_wdata_i[8:0];
      default: ctrl_nxt = reg_wdata_i[8:0];
    endcase
  end

  assign run_req_d = ctrl_we ? (ctrl_nxt[0] && (sync_on || run_req)) : run_req;

  // raster position
  logic [CW:0] h_end, v_end;
  logic        hs_act, vs_act, de_act;
  assign h_end  = {1'b0, h_wait} + {1'b0, h_act};
  assign v_end  = {1'b0, v_wait} + {1'b0, v_act};
  assign hs_act = sync_on && hcnt < hs_w;
  assign vs_act = sync_on && vcnt < vs_w;
  assign de_act = sync_on && run_act && hcnt >= h_wait && {1'b0, hcnt} < h_end
                  && vcnt >= v_wait && {1'b0, vcnt} < v_end;

  assign hsync_o       = hs_hi ? hs_act : ~hs_act;
  assign vsync_o       = vs_hi ? vs_act : ~vs_act;
  assign de_o          = de_hi ? de_act : ~de_act;
  assign dclk_fall_o   = dclk_fall;
  assign frame_start_o = sync_on && hcnt == '0 && vcnt == '0;
  assign fifo_rd_o     = de_act && !fifo_empty_i;
  assign pix_o         = fifo_empty_i ? last_pix : fifo_data_i;
  assign fetch_addr_o  = cur_buf;
  assign underflow_o   = uflow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!sync_on) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt >= line_tot - ONE) begin
      hcnt <= '0;
      vcnt <= (vcnt >= frame_tot - ONE) ? '0 : vcnt + ONE;
    end else begin
      hcnt <= hcnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run_req, run_act, sync_on, hs_hi, vs_hi, de_hi, dclk_fall, uflow} <= '0;
      {line_tot, hs_w, frame_tot, vs_w, h_wait, v_wait, h_act, v_act} <= '0;
      nxt_buf  <= '0;
      cur_buf  <= '0;
      last_pix <= '0;
    end else begin
      run_req <= run_req_d;
      run_act <= run_req_d || (run_act && !fifo_empty_i);
      uflow   <= (ctrl_we ? (ctrl_nxt[8] && uflow) : uflow) || (de_act && fifo_empty_i);
      if (ctrl_we) {dclk_fall, de_hi, vs_hi, hs_hi, sync_on} <= ctrl_nxt[5:1];
      if (reg_wr_i && rop == 4'h0) begin
        case (rsel)
          4'h1: {hs_w, line_tot}  <= {reg_wdata_i[16 +: CW], reg_wdata_i[CW-1:0]};
          4'h2: {vs_w, frame_tot} <= {reg_wdata_i[16 +: CW], reg_wdata_i[CW-1:0]};
          4'h3: {v_wait, h_wait}  <= {reg_wdata_i[16 +: CW], reg_wdata_i[CW-1:0]};
          4'h4: {v_act, h_act}    <= {reg_wdata_i[16 +: CW], reg_wdata_i[CW-1:0]};
          4'h5: nxt_buf           <= reg_wdata_i[AW-1:0];
          default: ;
        endcase
      end
      if (frame_start_o) cur_buf <= nxt_buf;
      if (fifo_rd_o) last_pix <= fifo_data_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (rsel)
      4'h0: reg_rdata_o[8:0] = {uflow, 2'b00, dclk_fall, de_hi, vs_hi, hs_hi, sync_on, run_act};
      4'h1: reg_rdata_o = {16'(hs_w), 16'(line_tot)};
      4'h2: reg_rdata_o = {16'(vs_w), 16'(frame_tot)};
      4'h3: reg_rdata_o = {16'(v_wait), 16'(h_wait)};
      4'h4: reg_rdata_o = {16'(v_act), 16'(h_act)};
      4'h5: reg_rdata_o = 32'(nxt_buf);
      4'h6: reg_rdata_o = 32'(cur_buf);
      default: ;
    endcase
  end

  p_no_read_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty_i |-> !fifo_rd_o);
  p_fs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && line_tot > ONE) |=> !frame_start_o);
  p_cur_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_o |=> $stable(fetch_addr_o));
  p_run_after_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_act ##1 run_act |-> $past(sync_on));
  p_drain_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req && !reg_wr_i && fifo_empty_i) |=> !run_act);
endmodule

// File: tb/tb_lcd_dotclk_timing.sv
`timescale 1ns/1ps
module tb_lcd_dotclk_timing;
  localparam int PW = 24;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fifo_empty = 0;
  logic [PW-1:0] fifo_data = 100;
  logic fifo_rd, hsync, vsync, de, dclk_fall, fs, uflow;
  logic [PW-1:0] pix;
  logic [31:0] faddr;
  int total = 0, bad = 0;
  bit done = 0, mon_en = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  lcd_dotclk_timing dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .pix_o(pix), .dclk_fall_o(dclk_fall), .frame_start_o(fs),
    .fetch_addr_o(faddr), .underflow_o(uflow));

  // upstream FIFO model: head word advances on each read
  always @(posedge clk) if (fifo_rd && !fifo_empty) fifo_data <= fifo_data + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every active pixel pops one expected word (R9)
  always @(negedge clk) begin
    if (mon_en && de === 1'b1) begin
      if (exp_q.size() == 0) chk("R4 unexpected data-enable", 1, 0);
      else chk("R9 pixel word", int'(pix), exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int e_hs, e_vs, e_de, e_fs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, default active-low polarities
    chk("R1 hsync idle", hsync, 1); chk("R1 vsync idle", vsync, 1);
    chk("R1 de idle", de, 1); chk("R1 frame_start", fs, 0);
    rd(8'h00, r); chk("R1 ctrl reset", r, 0);
    chk("R1 fetch addr", faddr, 0);

    wr(8'h10, (2 << 16) | 10);
    wr(8'h20, (1 << 16) | 6);
    wr(8'h30, (2 << 16) | 4);
    wr(8'h40, (3 << 16) | 4);
    wr(8'h50, 32'h1000);
    wr(8'h04, 32'h1C);                  // R8 set alias: polarities high
    wr(8'h04, 32'h01);                  // R7 run before sync: ignored
    rd(8'h00, r); chk("R7 run ignored without sync", r, 32'h1C);
    chk("R5 active-high idle hsync", hsync, 0);

    for (int v = 100; v < 124; v++) exp_q.push_back(v);
    for (int k = 0; k < 12; k++) exp_q.push_back(123);
    mon_en = 1;
    wr(8'h04, 32'h02);                  // sync on: this negedge is c=0
    e_hs = 0; e_vs = 0; e_de = 0; e_fs = 0;
    for (int c = 0; c < 180; c++) begin
      int h, v;
      bit xde;
      if (c > 0) @(negedge clk);
      h = c % 10; v = (c / 10) % 6;
      xde = (c >= 1) && v >= 2 && v < 5 && h >= 4 && h < 8;
      if (hsync !== (h < 2)) e_hs++;
      if (vsync !== (v < 1)) e_vs++;
      if (de !== xde) e_de++;
      if (fs !== (h == 0 && v == 0)) e_fs++;
      if (c == 0) begin reg_wr = 1; reg_addr = 8'h04; reg_wdata = 32'h01; end
      if (c == 1) reg_wr = 0;
      if (c == 5) chk("R6 base taken at frame start", faddr, 32'h1000);
      if (c == 70) begin reg_wr = 1; reg_addr = 8'h50; reg_wdata = 32'h2000; end
      if (c == 71) reg_wr = 0;
      if (c == 100) chk("R6 next base held until frame start", faddr, 32'h1000);
      if (c == 119) fifo_empty = 1;
      if (c == 121) chk("R6 next base after frame start", faddr, 32'h2000);
    end
    chk("R2 hsync placement", e_hs, 0);
    chk("R3 vsync placement", e_vs, 0);
    chk("R4 data-enable window", e_de, 0);
    chk("R6 frame_start pulse", e_fs, 0);
    chk("R9 scoreboard drained", exp_q.size(), 0);

    chk("R9 underflow output", uflow, 1);
    rd(8'h00, r); chk("R9 underflow ctrl bit", r[8], 1);
    fifo_empty = 0;
    wr(8'h08, 32'h100);
    rd(8'h00, r); chk("R9 underflow cleared", r[8], 0);

    wr(8'h08, 32'h01);                  // clear run with data still present
    rd(8'h00, r); chk("R7 run held while draining", r[0], 1);
    fifo_empty = 1;
    @(negedge clk);
    rd(8'h00, r); chk("R7 run reads zero after empty", r[0], 0);
    e_de = 0;
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      if (de !== 1'b0) e_de++;
    end
    chk("R4 no data-enable after run stops", e_de, 0);
    mon_en = 0;

    wr(8'h08, 32'h02);                  // sync off
    @(negedge clk);
    chk("R1 hsync inactive sync off", hsync, 0);
    chk("R1 vsync inactive sync off", vsync, 0);
    chk("R1 frame_start sync off", fs, 0);
    wr(8'h08, 32'h1C);                  // R8 clear alias: polarities low
    chk("R5 active-low hsync idle", hsync, 1);
    chk("R5 active-low de idle", de, 1);
    wr(8'h04, 32'h20);
    chk("R5 falling-edge select", dclk_fall, 1);
    rd(8'h00, r); chk("R8 set/clear result", r, 32'h20);
    wr(8'h00, 32'h02);                  // direct write: only sync on
    rd(8'h00, r); chk("R8 direct write", r, 32'h02);
    chk("R1 restart at line 0 pixel 0", fs, 1);
    chk("R5 active-low hsync asserted", hsync, 0);
    @(negedge clk);
    chk("R6 frame_start one clock", fs, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule